// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial slave that lets a host microcontroller read and write a small file of 8-bit control registers inside the modem. The host frames each access with an active-high enable, clocks bits in on a shift clock, presents address and data on a serial input, and receives read data on a serial output. That output carries an explicit output-enable so the pad can be tri-stated.

The whole block runs on the system clock. The shift clock, enable and serial input are brought in through synchronizers and edge-detected, so the shift clock must be slower than the system clock (10 MHz against 100 MHz leaves ample margin). The register contents are exported as one packed parallel bus. The two low bits of register 0 are also exported on their own as the monitor source select.

Top module: `sctl_port`

## Requirements
- R1: After rst_ni is driven low, every register reads 0x00, regs_o is all zero and sdo_oe_o is 0.
- R2: A frame is one direction bit (0 = write, 1 = read), then address bits A2, A1, A0, then data bits B7 down to B0. Each bit is taken on a rising shift-clock edge while sen_i is high.
- R3: A write updates its register only after the eighth data bit has been taken. Dropping sen_i before that abandons the frame and leaves every register unchanged.
- R4: On a read, the addressed register is driven on sdo_o from B7 down to B0, one bit per shift-clock period, starting at the falling edge that follows A0. sdo_oe_o is 1 only during those eight bit periods.
- R5: The unused bits are the low 4 bits of register 2 and the low 3 bits of registers 3 and 4. Writes to them are discarded, and they always read as 0.
- R6: Addresses 6 and 7 hold no register. Writes to them change nothing, and reads from them return 0x00.
- R7: regs_o[8k+7:8k] holds register k. mon_sel_o equals bits [1:0] of register 0, with 00 = envelope, 01 = phase detect, 10 = delay detect, 11 = frequency-control data.
- R8: sdo_o changes only after a falling shift-clock edge. It holds steady across each rising edge at which the host samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sen_i | input | 1 | Frame enable from host, active high |
| sclk_i | input | 1 | Serial shift clock from host |
| sdi_i | input | 1 | Serial direction/address/data input |
| sdo_o | output | 1 | Serial read data output |
| sdo_oe_o | output | 1 | Output enable for sdo_o pad (0 = high impedance) |
| regs_o | output | 48 | Packed register contents, register k at bits [8k+7:8k] |
| mon_sel_o | output | 2 | Monitor source select, bits [1:0] of register 0 |

## Verification
The bench builds the block with its default values: six registers of eight bits, a three-bit address and two synchronizer stages. At that size every one of the eight addresses can be written with a set of data patterns and read back. All-ones and all-zeros words reach every implemented bit and every unused bit, so the per-register masks and the two empty addresses are covered exhaustively. The bench also aborts frames, sweeps all four monitor select codes, and checks at the pins that the output enable and data stay quiet and steady.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;

  // bits of register idx that are implemented
  function automatic logic [DW-1:0] keep_mask(input int unsigned idx);
    case (idx)
      2:       keep_mask = 8'hF0;
      3, 4:    keep_mask = 8'hF8;
      default: keep_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
  import sctl_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned ADDR_W = AW,
  localparam int unsigned HDR   = 1 + ADDR_W,
  localparam int unsigned FRAME = HDR + DATA_W,
  localparam int unsigned CW    = $clog2(FRAME + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              rise_o,
  output logic              fall_o,
  output logic [CW-1:0]     cnt_o
);
  logic              sclk_d;
  logic [CW-1:0]     cnt_q;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dat_q;
  logic [DATA_W-1:0] shadow_q;
  logic              wr_q;
  logic              sdo_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_d;
  assign fall_o = ~sclk_i & sclk_d;

  // capture side: rising edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      addr_q <= '0;
      dat_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (rise_o && cnt_q != CW'(FRAME)) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0)
          dir_q <= sdi_i;
        else if (cnt_q < CW'(HDR))
          addr_q <= {addr_q[ADDR_W-2:0], sdi_i};
        else
          dat_q <= {dat_q[DATA_W-2:0], sdi_i};
        if (cnt_q == CW'(FRAME - 1) && !dir_q)
          wr_q <= 1'b1;
      end
    end
  end

  // drive side: falling edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else if (!en_i) begin
      oe_q <= 1'b0;
    end else if (fall_o && dir_q) begin
      if (cnt_q == CW'(HDR)) begin
        shadow_q <= rdata_i;
        sdo_q    <= rdata_i[DATA_W-1];
        oe_q     <= 1'b1;
      end else if (cnt_q > CW'(HDR) && cnt_q < CW'(FRAME)) begin
        sdo_q <= shadow_q[CW'(FRAME - 1) - cnt_q];
      end else if (cnt_q == CW'(FRAME)) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign addr_o   = addr_q;
  assign wr_o     = wr_q;
  assign wdata_o  = dat_q;
  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
  import sctl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned DATA_W   = DW,
  parameter int unsigned ADDR_W   = AW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] r_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = keep_mask(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        r_q[i] <= '0;
      else if (wr_i && addr_i == ADDR_W'(i))
        r_q[i] <= wdata_i & MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (addr_i == ADDR_W'(k)) rdata_o = r_q[k];
  end

  assign regs_o = r_q;
endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 6,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RW         = NUM_REGS * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sen_i,
  input  logic          sclk_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [RW-1:0] regs_o,
  output logic [1:0]    mon_sel_o
);
  localparam int unsigned CW = $clog2(1 + AW + DW + 1);

  logic en_s, sclk_s, sdi_s;
  logic rise_s, fall_s;
  logic wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [CW-1:0] cnt;

  sctl_sync #(.STAGES(SYNC_STAGES)) u_sync_en   (.clk_i, .rst_ni, .d_i(sen_i),  .q_o(en_s));
  sctl_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (.clk_i, .rst_ni, .d_i(sclk_i), .q_o(sclk_s));
  sctl_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi  (.clk_i, .rst_ni, .d_i(sdi_i),  .q_o(sdi_s));

  sctl_frame #(.DATA_W(DW), .ADDR_W(AW)) u_frame (
    .clk_i, .rst_ni,
    .en_i    (en_s),
    .sclk_i  (sclk_s),
    .sdi_i   (sdi_s),
    .rdata_i (rdata),
    .addr_o  (addr),
    .wr_o    (wr),
    .wdata_o (wdata),
    .sdo_o,
    .sdo_oe_o,
    .rise_o  (rise_s),
    .fall_o  (fall_s),
    .cnt_o   (cnt)
  );

  sctl_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DW), .ADDR_W(AW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i    (wr),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .regs_o
  );

  assign mon_sel_o = regs_o[1:0];
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk #(
  parameter int unsigned RW = 48,
  parameter int unsigned CW = 4,
  parameter int unsigned FRAME = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_s,
  input logic          rise_s,
  input logic          fall_s,
  input logic [CW-1:0] cnt,
  input logic          sdo_o,
  input logic          sdo_oe_o,
  input logic [RW-1:0] regs_o
);
  // R4: output enabled only inside an active frame
  a_r4_oe_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> en_s);

  // R4: output enable turns on only after a falling shift edge
  a_r4_oe_rise_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(fall_s));

  // R8: driven data holds unless a falling edge occurred
  a_r8_sdo_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !$past(fall_s)) |-> $stable(sdo_o));

  // R3: registers change only two cycles after a captured shift edge
  a_r3_commit_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(rise_s, 2));

  // R2: bit counter never runs past one frame
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(FRAME));
endmodule

bind sctl_port sctl_port_chk #(.RW(RW), .CW(CW), .FRAME(1 + sctl_pkg::AW + sctl_pkg::DW)) u_chk (
  .clk_i, .rst_ni, .en_s, .rise_s, .fall_s, .cnt, .sdo_o, .sdo_oe_o, .regs_o
);

// File: tb/sctl_port_test.sv
module sctl_port_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sen_i = 1'b0, sclk_i = 1'b0, sdi_i = 1'b0;
  logic        sdo_o, sdo_oe_o;
  logic [47:0] regs_o;
  logic [1:0]  mon_sel_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] model [8];
  bit done = 1'b0;

  always #5 clk = ~clk;

  sctl_port uut (.clk_i(clk), .rst_ni, .sen_i, .sclk_i, .sdi_i,
                 .sdo_o, .sdo_oe_o, .regs_o, .mon_sel_o);

  function automatic logic [7:0] mask_of(input int a);
    case (a)
      2: mask_of = 8'hF0;
      3, 4: mask_of = 8'hF8;
      6, 7: mask_of = 8'h00;
      default: mask_of = 8'hFF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // one frame; stop_at < 12 aborts before that bit
  task automatic xfer(input bit rd, input logic [2:0] a, input logic [7:0] d, input int stop_at,
                      output logic [7:0] q, output int oe_bad, output int moved);
    logic [11:0] bits;
    logic pre;
    bits = {rd, a, d};
    q = '0; oe_bad = 0; moved = 0;
    @(negedge clk); sen_i = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      if (i == stop_at) break;
      sdi_i = bits[11-i];
      repeat (5) @(negedge clk);
      pre = sdo_o;
      if (rd && i >= 4) begin
        q[11-i] = sdo_o;
        if (!sdo_oe_o) oe_bad++;
      end else if (sdo_oe_o) oe_bad++;
      sclk_i = 1'b1;
      repeat (5) @(negedge clk);
      if (rd && i >= 4 && sdo_o !== pre) moved++;
      sclk_i = 1'b0;
    end
    repeat (5) @(negedge clk);
    sen_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q; int ob, mv;
    xfer(1'b0, a, d, 12, q, ob, mv);
    chk(ob == 0, "R4 oe during write", ob, 0);
    model[a] = d & mask_of(a);
  endtask

  task automatic rd_chk(input logic [2:0] a, input string req);
    logic [7:0] q; int ob, mv;
    xfer(1'b1, a, 8'h00, 12, q, ob, mv);
    chk(q == model[a], req, q, model[a]);
    chk(ob == 0, "R4 oe window", ob, 0);
    chk(mv == 0, "R8 sdo steady", mv, 0);
    chk(sdo_oe_o == 1'b0, "R4 oe off after frame", sdo_oe_o, 0);
  endtask

  task automatic par_chk(input string req);
    for (int k = 0; k < 6; k++)
      chk(regs_o[8*k +: 8] == model[k], req, regs_o[8*k +: 8], model[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      summary();
    end
  end

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    logic [7:0] q; int ob, mv;
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(regs_o == '0, "R1 regs after reset", regs_o, 0);
    chk(sdo_oe_o == 1'b0, "R1 oe after reset", sdo_oe_o, 0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R1 read after reset");

    // R2 R5 R6: sweep addresses and patterns
    foreach (pats[p]) begin
      for (int a = 0; a < 8; a++) begin
        wr(3'(a), pats[p] ^ 8'(a));
        par_chk(a >= 6 ? "R6 ignored write" : "R7 parallel view");
        rd_chk(3'(a), a >= 6 ? "R6 empty read" : (a >= 2 && a <= 4) ? "R5 masked read" : "R2 readback");
      end
    end

    // R3: aborted writes
    wr(3'd1, 8'h3C);
    for (int s = 1; s < 12; s++) begin
      xfer(1'b0, 3'd1, 8'hC3, s, q, ob, mv);
      par_chk("R3 aborted write");
    end
    rd_chk(3'd1, "R3 value after aborts");

    // R2: a read frame leaves contents alone
    xfer(1'b1, 3'd5, 8'hFF, 12, q, ob, mv);
    par_chk("R2 read has no side effect");

    // R7: monitor select codes
    for (int v = 0; v < 4; v++) begin
      wr(3'd0, 8'(v) | 8'hC0);
      chk(mon_sel_o == 2'(v), "R7 mon_sel", mon_sel_o, v);
    end

    // R1: reset again after activity
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk); rst_ni = 1'b1;
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    repeat (3) @(negedge clk);
    chk(regs_o == '0, "R1 second reset", regs_o, 0);
    rd_chk(3'd0, "R1 read after second reset");

    done = 1'b1;
    summary();
  end
endmodule